// File: doc/BRIEF.md
# Masked Read-Modify-Write Engine

This block updates one multi-word table entry on behalf of a host. It does not give the host direct access to the memory. The host loads the following through an 8-bit register bus, with the engine idle:

- new data for each of the fourteen 16-bit words of the entry;
- bit masks for the low words;
- a keep flag for each of the high words;
- the entry address;
- a control byte that names the target memory and the direction, and sets a start bit.

The engine then works through the entry one word per cycle:

1. It reads every word of the entry from the selected memory and keeps a copy.
2. It merges the staged data with those words under the masks.
3. It writes the merged words back.

The pre-modification contents are left in read-data registers. The start bit drops by itself when the work is done, so the host simply polls the control byte.

Three memories sit behind one word-wide synchronous port, which has a read latency of one cycle.

- The external table memory takes full 14-word entries.
- The monitoring memory takes 3-word entries at addresses below 128.
- The collection memory also takes 3-word entries at addresses below 128.

An update of the monitoring memory also repeats the merge at a linked entry, whose address is carried in the staged data. An illegal request is refused with an error flag and touches no memory.

Top module: `rmw_engine`

## Requirements
- R1: After reset every staging register, every read-data register and the control byte read 0, and the memory port stays idle.
- R2: For words 0..6, each result bit is the old bit where the word's bit-mask register holds 1 and the new data bit where it holds 0.
- R3: For words 7..13, bit k-7 of the word-keep register selects the whole old word k (1) or the whole new word k (0).
- R4: When an operation finishes, the read-data registers of the words it handled hold the contents those words had before the operation.
- R5: Writing 1 to control bit 3 starts an operation; the bit reads 1 while the operation runs and returns to 0 by itself when it ends; the memory port is used only while the bit is 1.
- R6: Control bits 5:4 pick the target: 01 external (14 words, low 12 address bits), 10 monitoring, 11 collection. Control bit 2 is the direction, 1 for upstream and 0 for downstream, and it is driven on `mem_up`.
- R7: For targets 10 and 11, only words 0..2 are read and written; the other words of the entry and of the read-data registers are left as they were.
- R8: For target 10, after the entry at the programmed address is written, the same merge is applied to the 3-word entry at the address given by bits 6:0 of staged data word 0.
- R9: Target 00, or target 10/11 with an address above 127, ends the operation without any memory access. Such a request clears the start bit and sets error bit 6 of the control byte. The next accepted start clears that bit.
- R10: Host writes to any register are ignored while the start bit is 1.
- R11: An accepted operation reads each handled word once, in ascending order, before writing them in ascending order. That is 14 reads and 14 writes for the external target, 6 and 6 for the monitoring target, and 3 and 3 for the collection target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | 8 | Register byte address: write data 0x00-0x1B, read data 0x20-0x3B, bit masks 0x40-0x4D, word-keep 0x50, address 0x52/0x53, control 0x58 |
| hwe | input | 1 | Register write strobe |
| hwdata | input | 8 | Register write byte |
| hrdata | output | 8 | Register read byte for `haddr` (combinational) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_tgt | output | 2 | Target memory code |
| mem_up | output | 1 | Direction: 1 upstream, 0 downstream |
| mem_addr | output | 12 | Entry address |
| mem_idx | output | 4 | Word index inside the entry |
| mem_wdata | output | 16 | Merged word to write |
| mem_rdata | input | 16 | Read word, valid one cycle after a read |

## Verification
The bound checker watches the memory port on every cycle:

- the port stays silent while the start bit is clear;
- a write is never issued without an access;
- the null target never reaches the port;
- a short target never shows a word index above 2 or an address above 127;
- reads step through the word indices without a gap.

The values involved can only be shown by the bench's scenarios, which compare them with a bench model of the three memories:

- the merged data under mixed bit and word masks;
- the linked second entry of the monitoring target, including the case where it equals the first;
- the old contents returned in the read-data registers;
- the error flag's set and clear;
- writes made while busy having no effect.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int WORD_W      = 16;
  localparam int N_WORDS     = 14;
  localparam int N_BITMASK   = 7;
  localparam int N_KEEP      = N_WORDS - N_BITMASK;
  localparam int N_SHORT     = 3;
  localparam int IDX_W       = $clog2(N_WORDS);
  localparam int SHORT_DEPTH = 128;
  localparam int SHORT_AW    = $clog2(SHORT_DEPTH);
  localparam int HA_W        = 8;
  localparam int HD_W        = 8;
  localparam int EA_W        = 16;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_EXT  = 2'b01,
    TGT_MON  = 2'b10,
    TGT_COL  = 2'b11
  } tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MERGE, ST_WRITE, ST_DONE
  } st_e;

  // register map: haddr[7:5] picks a region, haddr[4:0] the byte in it
  localparam logic [2:0] RG_WD  = 3'd0;
  localparam logic [2:0] RG_RD  = 3'd1;
  localparam logic [2:0] RG_CFG = 3'd2;
  localparam logic [4:0] OFS_KEEP   = 5'd16;
  localparam logic [4:0] OFS_ADDR_L = 5'd18;
  localparam logic [4:0] OFS_ADDR_H = 5'd19;
  localparam logic [4:0] OFS_CTRL   = 5'd24;

  localparam int CB_UP    = 2;
  localparam int CB_START = 3;
  localparam int CB_TGT   = 4;
  localparam int CB_ERR   = 6;
endpackage

// File: rtl/rmw_regs.sv
module rmw_regs
  import rmw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HA_W-1:0]         haddr,
  input  logic                    hwe,
  input  logic [HD_W-1:0]         hwdata,
  output logic [HD_W-1:0]         hrdata,
  output word_t [N_WORDS-1:0]     wd_o,
  output word_t [N_BITMASK-1:0]   bmask_o,
  output logic [N_KEEP-1:0]       keep_o,
  output logic [EA_W-1:0]         eaddr_o,
  output tgt_e                    tgt_o,
  output logic                    up_o,
  output logic                    start_o,
  output logic                    err_o,
  input  logic                    cap_en,
  input  logic                    cap_first,
  input  logic [IDX_W-1:0]        cap_idx,
  input  word_t                   cap_data,
  input  logic                    launch,
  input  logic                    abort,
  input  logic                    done
);
  word_t [N_WORDS-1:0]   wd_q;
  word_t [N_WORDS-1:0]   rd_q;
  word_t [N_BITMASK-1:0] bm_q;
  logic [N_KEEP-1:0]     keep_q;
  logic [EA_W-1:0]       ea_q;
  tgt_e                  tgt_q;
  logic                  up_q, start_q, err_q;

  logic       wr_ok;
  logic [2:0] region;
  logic [4:0] ofs;

  assign wr_ok  = hwe && !start_q;
  assign region = haddr[7:5];
  assign ofs    = haddr[4:0];

  // write data and read data words
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic wlo, whi, cap_hit;
    assign wlo     = wr_ok && (region == RG_WD) && (ofs == 5'(2*w));
    assign whi     = wr_ok && (region == RG_WD) && (ofs == 5'(2*w+1));
    assign cap_hit = cap_en && cap_first && (cap_idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wd_q[w] <= '0;
      end else begin
        if (wlo) wd_q[w][7:0]  <= hwdata;
        if (whi) wd_q[w][15:8] <= hwdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q[w] <= '0;
      else if (cap_hit) rd_q[w] <= cap_data;
    end
  end

  // bit masks for the low words
  for (genvar w = 0; w < N_BITMASK; w++) begin : g_bmask
    logic wlo, whi;
    assign wlo = wr_ok && (region == RG_CFG) && (ofs == 5'(2*w));
    assign whi = wr_ok && (region == RG_CFG) && (ofs == 5'(2*w+1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bm_q[w] <= '0;
      end else begin
        if (wlo) bm_q[w][7:0]  <= hwdata;
        if (whi) bm_q[w][15:8] <= hwdata;
      end
    end
  end

  logic keep_we, eal_we, eah_we, ctrl_we;
  assign keep_we = wr_ok && (region == RG_CFG) && (ofs == OFS_KEEP);
  assign eal_we  = wr_ok && (region == RG_CFG) && (ofs == OFS_ADDR_L);
  assign eah_we  = wr_ok && (region == RG_CFG) && (ofs == OFS_ADDR_H);
  assign ctrl_we = wr_ok && (region == RG_CFG) && (ofs == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
      ea_q   <= '0;
    end else begin
      if (keep_we) keep_q     <= hwdata[N_KEEP-1:0];
      if (eal_we)  ea_q[7:0]  <= hwdata;
      if (eah_we)  ea_q[15:8] <= hwdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= TGT_NONE;
      up_q    <= 1'b0;
      start_q <= 1'b0;
    end else if (ctrl_we) begin
      tgt_q   <= tgt_e'(hwdata[CB_TGT+1:CB_TGT]);
      up_q    <= hwdata[CB_UP];
      start_q <= hwdata[CB_START];
    end else if (done) begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (abort)  err_q <= 1'b1;
    else if (launch) err_q <= 1'b0;
  end

  // host read mux
  always_comb begin
    hrdata = '0;
    unique case (region)
      RG_WD: begin
        for (int w = 0; w < N_WORDS; w++)
          if (ofs[4:1] == 4'(w)) hrdata = ofs[0] ? wd_q[w][15:8] : wd_q[w][7:0];
      end
      RG_RD: begin
        for (int w = 0; w < N_WORDS; w++)
          if (ofs[4:1] == 4'(w)) hrdata = ofs[0] ? rd_q[w][15:8] : rd_q[w][7:0];
      end
      RG_CFG: begin
        for (int w = 0; w < N_BITMASK; w++)
          if (ofs[4:1] == 4'(w)) hrdata = ofs[0] ? bm_q[w][15:8] : bm_q[w][7:0];
        if (ofs == OFS_KEEP)   hrdata = HD_W'(keep_q);
        if (ofs == OFS_ADDR_L) hrdata = ea_q[7:0];
        if (ofs == OFS_ADDR_H) hrdata = ea_q[15:8];
        if (ofs == OFS_CTRL)   hrdata = {1'b0, err_q, tgt_q, start_q, up_q, 2'b00};
      end
      default: hrdata = '0;
    endcase
  end

  assign wd_o    = wd_q;
  assign bmask_o = bm_q;
  assign keep_o  = keep_q;
  assign eaddr_o = ea_q;
  assign tgt_o   = tgt_q;
  assign up_o    = up_q;
  assign start_o = start_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import rmw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_en,
  input  logic [IDX_W-1:0]      cap_idx,
  input  word_t                 cap_data,
  input  word_t [N_WORDS-1:0]   wd,
  input  word_t [N_BITMASK-1:0] bmask,
  input  logic [N_KEEP-1:0]     keep,
  input  logic [IDX_W-1:0]      sel_idx,
  output word_t                 merged_o
);
  word_t [N_WORDS-1:0] old_q;
  word_t [N_WORDS-1:0] merged;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                old_q[w] <= '0;
      else if (cap_en && cap_idx == IDX_W'(w))   old_q[w] <= cap_data;
    end

    if (w < N_BITMASK) begin : g_bit
      assign merged[w] = (wd[w] & ~bmask[w]) | (old_q[w] & bmask[w]);
    end else begin : g_whole
      assign merged[w] = keep[w-N_BITMASK] ? old_q[w] : wd[w];
    end
  end

  always_comb begin
    merged_o = '0;
    for (int w = 0; w < N_WORDS; w++)
      if (sel_idx == IDX_W'(w)) merged_o = merged[w];
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  tgt_e                tgt,
  input  logic [EA_W-1:0]     eaddr,
  input  logic [SHORT_AW-1:0] link_addr,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [IDX_W-1:0]    mem_idx,
  output logic                cap_en,
  output logic                cap_first,
  output logic [IDX_W-1:0]    cap_idx,
  output logic                launch,
  output logic                abort,
  output logic                done
);
  st_e                st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               pass_q, pass_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               rpend_q;
  logic [IDX_W-1:0]   ridx_q;

  logic               is_short;
  logic [IDX_W-1:0]   last;
  logic               at_last;

  assign is_short = (tgt == TGT_MON) || (tgt == TGT_COL);
  assign last     = is_short ? IDX_W'(N_SHORT-1) : IDX_W'(N_WORDS-1);
  assign at_last  = (idx_q == last);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    pass_d = pass_q;
    addr_d = addr_q;
    launch = 1'b0;
    abort  = 1'b0;
    done   = 1'b0;
    mem_en = 1'b0;
    mem_we = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (tgt == TGT_NONE || (is_short && eaddr >= EA_W'(SHORT_DEPTH))) begin
            abort = 1'b1;
            st_d  = ST_DONE;
          end else begin
            launch = 1'b1;
            idx_d  = '0;
            pass_d = 1'b0;
            addr_d = is_short ? ADDR_W'(eaddr[SHORT_AW-1:0]) : eaddr[ADDR_W-1:0];
            st_d   = ST_READ;
          end
        end
      end
      ST_READ: begin
        mem_en = 1'b1;
        if (at_last) begin
          idx_d = '0;
          st_d  = ST_MERGE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_MERGE: st_d = ST_WRITE;
      ST_WRITE: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        if (!at_last) begin
          idx_d = idx_q + 1'b1;
        end else if (tgt == TGT_MON && !pass_q) begin
          pass_d = 1'b1;
          idx_d  = '0;
          addr_d = ADDR_W'(link_addr);
          st_d   = ST_READ;
        end else begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      pass_q  <= 1'b0;
      addr_q  <= '0;
      rpend_q <= 1'b0;
      ridx_q  <= '0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      pass_q  <= pass_d;
      addr_q  <= addr_d;
      rpend_q <= (st_q == ST_READ);
      if (st_q == ST_READ) ridx_q <= idx_q;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_idx   = idx_q;
  assign cap_en    = rpend_q;
  assign cap_idx   = ridx_q;
  assign cap_first = !pass_q;
endmodule

// File: rtl/rmw_engine.sv
module rmw_engine
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        haddr,
  input  logic              hwe,
  input  logic [7:0]        hwdata,
  output logic [7:0]        hrdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [1:0]        mem_tgt,
  output logic              mem_up,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_idx,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  word_t [N_WORDS-1:0]   wd;
  word_t [N_BITMASK-1:0] bmask;
  logic [N_KEEP-1:0]     keep;
  logic [EA_W-1:0]       eaddr;
  tgt_e                  tgt;
  logic                  up, start_w, err_w;
  logic                  cap_en, cap_first, launch, abort, done;
  logic [IDX_W-1:0]      cap_idx, idx_w;
  word_t                 merged;

  rmw_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .haddr     (haddr),
    .hwe       (hwe),
    .hwdata    (hwdata),
    .hrdata    (hrdata),
    .wd_o      (wd),
    .bmask_o   (bmask),
    .keep_o    (keep),
    .eaddr_o   (eaddr),
    .tgt_o     (tgt),
    .up_o      (up),
    .start_o   (start_w),
    .err_o     (err_w),
    .cap_en    (cap_en),
    .cap_first (cap_first),
    .cap_idx   (cap_idx),
    .cap_data  (mem_rdata),
    .launch    (launch),
    .abort     (abort),
    .done      (done)
  );

  rmw_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start_w),
    .tgt       (tgt),
    .eaddr     (eaddr),
    .link_addr (wd[0][SHORT_AW-1:0]),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_idx   (idx_w),
    .cap_en    (cap_en),
    .cap_first (cap_first),
    .cap_idx   (cap_idx),
    .launch    (launch),
    .abort     (abort),
    .done      (done)
  );

  rmw_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (mem_rdata),
    .wd       (wd),
    .bmask    (bmask),
    .keep     (keep),
    .sel_idx  (idx_w),
    .merged_o (merged)
  );

  assign mem_idx   = 4'(idx_w);
  assign mem_wdata = merged;
  assign mem_tgt   = tgt;
  assign mem_up    = up;
endmodule

// File: rtl/rmw_engine_chk.sv
module rmw_engine_chk
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_en,
  input logic              mem_we,
  input logic [1:0]        mem_tgt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_idx,
  input logic              start
);
  assert_port_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !mem_en);

  assert_we_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  assert_no_null_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_tgt != 2'b00);

  assert_short_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_tgt[1]) |-> mem_idx < 4'(N_SHORT));

  assert_short_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_tgt[1]) |-> mem_addr < ADDR_W'(SHORT_DEPTH));

  assert_read_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we && mem_idx != 4'd0) |->
      ($past(mem_en) && !$past(mem_we) && $past(mem_idx) == 4'(mem_idx - 4'd1)));
endmodule

bind rmw_engine rmw_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_tgt  (mem_tgt),
  .mem_addr (mem_addr),
  .mem_idx  (mem_idx),
  .start    (start_w)
);

// File: tb/test_rmw_engine.sv
`timescale 1ns/1ps
module test_rmw_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  haddr = '0;
  logic        hwe = 1'b0;
  logic [7:0]  hwdata = '0;
  logic [7:0]  hrdata;
  logic        mem_en, mem_we, mem_up;
  logic [1:0]  mem_tgt;
  logic [11:0] mem_addr;
  logic [3:0]  mem_idx;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int nrd = 0;
  int nwr = 0;
  logic [15:0] mem [int];
  logic [15:0] rd_exp [14];

  always #4 clk = ~clk;

  rmw_engine i_rmw_engine (
    .clk(clk), .rst_n(rst_n), .haddr(haddr), .hwe(hwe), .hwdata(hwdata),
    .hrdata(hrdata), .mem_en(mem_en), .mem_we(mem_we), .mem_tgt(mem_tgt),
    .mem_up(mem_up), .mem_addr(mem_addr), .mem_idx(mem_idx),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic int mkey(logic [1:0] t, logic u, logic [11:0] a, logic [3:0] i);
    return int'({t, u, a, i});
  endfunction

  function automatic logic [15:0] mget(int k);
    if (mem.exists(k)) return mem[k];
    return 16'((k * 40503) ^ 32'h5a5a);
  endfunction

  function automatic logic [15:0] mrg(int w, logic [15:0] d, logic [15:0] m,
                                      logic [6:0] keep, logic [15:0] o);
    if (w < 7) return (d & ~m) | (o & m);
    return keep[w-7] ? o : d;
  endfunction

  // memory model: synchronous, one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mkey(mem_tgt, mem_up, mem_addr, mem_idx)] = mem_wdata;
        nwr++;
      end else begin
        mem_rdata <= mget(mkey(mem_tgt, mem_up, mem_addr, mem_idx));
        nrd++;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    haddr = a; hwdata = d; hwe = 1'b1;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic hr(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    haddr = a;
    #1;
    d = hrdata;
  endtask

  task automatic hr16(logic [7:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    hr(a, lo);
    hr(a + 8'd1, hi);
    d = {hi, lo};
  endtask

  task automatic run_op(logic [1:0] tgt, logic up, logic [15:0] ea,
                        logic [15:0] wd [14], logic [15:0] bm [7],
                        logic [6:0] keep, bit poke);
    logic [15:0] oldA [14];
    logic [15:0] expA [14];
    logic [15:0] expB [3];
    logic [11:0] aA, aB;
    logic [7:0]  c;
    logic [15:0] v;
    int n, polls;
    bit shrt, bad;
    shrt = tgt[1];
    n    = (tgt == 2'b01) ? 14 : 3;
    bad  = (tgt == 2'b00) || (shrt && ea > 16'd127);
    aA   = shrt ? {5'b0, ea[6:0]} : ea[11:0];
    aB   = {5'b0, wd[0][6:0]};
    for (int w = 0; w < 14; w++) hw(8'(2*w), wd[w][7:0]);
    for (int w = 0; w < 14; w++) hw(8'(2*w+1), wd[w][15:8]);
    for (int w = 0; w < 7; w++) begin
      hw(8'h40 + 8'(2*w), bm[w][7:0]);
      hw(8'h41 + 8'(2*w), bm[w][15:8]);
    end
    hw(8'h50, {1'b0, keep});
    hw(8'h52, ea[7:0]);
    hw(8'h53, ea[15:8]);
    for (int w = 0; w < 14; w++) begin
      oldA[w] = mget(mkey(tgt, up, aA, 4'(w)));
      expA[w] = (!bad && w < n) ? mrg(w, wd[w], (w < 7) ? bm[w] : 16'h0, keep, oldA[w]) : oldA[w];
    end
    for (int w = 0; w < 3; w++)
      expB[w] = mrg(w, wd[w], bm[w], keep,
                    (aB == aA) ? expA[w] : mget(mkey(tgt, up, aB, 4'(w))));
    nrd = 0; nwr = 0;
    hw(8'h58, {2'b00, tgt, 1'b1, up, 2'b00});
    hr(8'h58, c);
    if (!bad) chk("R5 start reads 1 while busy", 32'(c[3]), 32'd1);
    if (poke) begin
      hw(8'h00, ~wd[0][7:0]);
      hw(8'h58, 8'h00);
    end
    polls = 0;
    do begin
      hr(8'h58, c);
      polls++;
    end while (c[3] && polls < 200);
    chk("R5 start self-clears", 32'(c[3]), 32'd0);
    chk("R9 error flag", 32'(c[6]), 32'(bad));
    chk("R6 target field kept", 32'(c[5:4]), 32'(tgt));
    chk("R11 read count", 32'(nrd), bad ? 32'd0 : ((tgt == 2'b10) ? 32'd6 : 32'(n)));
    chk("R11 write count", 32'(nwr), bad ? 32'd0 : ((tgt == 2'b10) ? 32'd6 : 32'(n)));
    if (!bad) for (int w = 0; w < n; w++) rd_exp[w] = oldA[w];
    for (int w = 0; w < 14; w++) begin
      hr16(8'h20 + 8'(2*w), v);
      chk(shrt ? "R7 R4 read-data register" : "R4 read-data register", 32'(v), 32'(rd_exp[w]));
    end
    if (!bad) for (int w = 0; w < 14; w++)
      chk((w < 7) ? "R2 R6 R7 entry word" : "R3 R6 R7 entry word",
          32'(mget(mkey(tgt, up, aA, 4'(w)))), 32'(expA[w]));
    if (!bad && tgt == 2'b10) for (int w = 0; w < 3; w++)
      chk("R8 linked entry word", 32'(mget(mkey(tgt, up, aB, 4'(w)))), 32'(expB[w]));
    if (poke) begin
      hr(8'h00, c);
      chk("R10 write data ignored while busy", 32'(c), 32'(wd[0][7:0]));
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] wd [14];
    logic [15:0] bm [7];
    logic [7:0]  c;
    void'($urandom(32'h1234abcd));
    for (int w = 0; w < 14; w++) rd_exp[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hr(8'h58, c); chk("R1 control after reset", 32'(c), 32'd0);
    hr(8'h00, c); chk("R1 write data after reset", 32'(c), 32'd0);
    hr(8'h21, c); chk("R1 read data after reset", 32'(c), 32'd0);
    hr(8'h50, c); chk("R1 word-keep after reset", 32'(c), 32'd0);
    hr(8'h4d, c); chk("R1 bit mask after reset", 32'(c), 32'd0);
    chk("R1 port idle", 32'(mem_en), 32'd0);
    chk("R1 no access", 32'(nrd + nwr), 32'd0);

    // external, no masks: full replace
    for (int w = 0; w < 14; w++) wd[w] = 16'h1000 + 16'(w * 257);
    for (int w = 0; w < 7; w++) bm[w] = 16'h0000;
    run_op(2'b01, 1'b1, 16'h0123, wd, bm, 7'h00, 1'b0);
    // external, everything kept
    for (int w = 0; w < 7; w++) bm[w] = 16'hffff;
    run_op(2'b01, 1'b0, 16'h0123, wd, bm, 7'h7f, 1'b0);
    // external, mixed masks, writes while busy
    for (int w = 0; w < 7; w++) bm[w] = 16'h0ff0;
    run_op(2'b01, 1'b1, 16'hf456, wd, bm, 7'h55, 1'b1);
    // monitoring, link equals own address
    wd[0] = 16'hab05;
    run_op(2'b10, 1'b0, 16'h0005, wd, bm, 7'h00, 1'b0);
    // monitoring, distinct link
    wd[0] = 16'h335a;
    run_op(2'b10, 1'b1, 16'h000a, wd, bm, 7'h00, 1'b0);
    // collection at top legal address
    run_op(2'b11, 1'b0, 16'h007f, wd, bm, 7'h00, 1'b0);
    // aborts: out of range, null target
    run_op(2'b10, 1'b0, 16'h0080, wd, bm, 7'h00, 1'b0);
    run_op(2'b00, 1'b1, 16'h0001, wd, bm, 7'h00, 1'b0);
    // a legal start clears the error flag (checked inside as R9)
    run_op(2'b11, 1'b1, 16'h0011, wd, bm, 7'h00, 1'b0);

    for (int k = 0; k < 24; k++) begin
      logic [1:0]  t;
      logic [15:0] ea;
      t = 2'(1 + ($urandom % 3));
      ea = 16'($urandom);
      if (t != 2'b01 && ($urandom % 8) != 0) ea = ea & 16'h007f;
      for (int w = 0; w < 14; w++) wd[w] = 16'($urandom);
      for (int w = 0; w < 7; w++) bm[w] = 16'($urandom);
      run_op(t, 1'($urandom), ea, wd, bm, 7'($urandom), k % 5 == 0);
    end
    finish_run();
  end
endmodule